// File: doc/BRIEF.md
# Per-Bank Pulse-Skipping Gate Modulator

This block takes one pulse-width-modulated gate stream and spreads it over a set of parallel power-device banks, one gate output per bank. It does not change pulse widths. For each bank it decides, pulse by pulse, whether the whole pulse is passed or dropped, so the bank's effective duty becomes a fraction of the shared input duty. Less conduction time means less heating in that bank.

Two schedules are supported. In rotation mode each bank drops one pulse per frame, with a different phase for each bank, so all but one bank conduct in every PWM period. In balancing mode the banks marked in a hot mask drop one pulse in every K, and every other bank passes every pulse. An outer loop decides which banks are hot and adjusts the shared duty. The block samples its settings once per suppression frame, so a change in the middle of a frame never breaks the schedule.

Top module: `pwm_skip_mod`

## Requirements
- R1: While `rst` is high, and on the first clock after it is sampled high, every gate output is low. A PWM pulse that is already high when reset is released is not passed to any bank.
- R2: Outputs are registered. A gate output can be high in a cycle only if `pwm_in` was high in the cycle before, and a passed pulse shows on the gate one clock after `pwm_in`, with the same width.
- R3: The pass or drop decision for a bank is made at the rising edge of `pwm_in` and holds for the whole pulse, so no output pulse is cut short or widened.
- R4: With `bal_mode`=0 (rotation), a frame is NUM_BANKS pulses long, counted from 0 at the frame's first pulse. Bank b drops the pulse at position b and passes all others, so exactly NUM_BANKS-1 banks conduct in every pulse.
- R5: With `bal_mode`=1 (balancing), a frame is K pulses long. A bank whose bit in `hot_mask` is 1 drops the pulse at position K-1 and passes the other K-1, so K=4 gives it three quarters of the input pulses. A bank whose bit is 0 passes every pulse.
- R6: Any number of banks can be marked hot at the same time, and each of them follows R5 on its own.
- R7: K is taken from `skip_ratio`. A value of 0 or 1 means no suppression, with a frame of one pulse. A value above NUM_BANKS is treated as NUM_BANKS.
- R8: `bal_mode`, `hot_mask` and `skip_ratio` are sampled only at the first pulse of a frame, and that sample is used for the whole frame. The first pulse after reset starts a frame.
- R9: In rotation mode, `hot_mask` and `skip_ratio` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Shared PWM gate stream, synchronous to `clk` |
| hot_mask | input | NUM_BANKS | Bit b = 1 marks bank b as hot (used in balancing mode) |
| bal_mode | input | 1 | 0 = rotation schedule, 1 = balancing schedule |
| skip_ratio | input | RATIO_W | Suppression ratio K for balancing mode |
| gate_out | output | NUM_BANKS | Registered per-bank gate drive |

## Verification
The bench builds the block with eight banks and a 4-bit ratio. That makes ratios from 9 to 15 reachable, so the clamp to eight is tested, as are 0 and 1 and the in-range values 2 and 4. With eight banks, a full rotation frame, several balancing frames and a frame that is interrupted by a settings change can all be run within a short test. Pulse widths go down to a single cycle high and a single cycle low, which tests the edge detector at its fastest rate.

// File: rtl/skip_pkg.sv
package skip_pkg;

  typedef enum logic {
    MODE_ROTATE  = 1'b0,
    MODE_BALANCE = 1'b1
  } skip_mode_e;

endpackage

// File: rtl/skip_edge_det.sv
module skip_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic pwm_in,
  output logic pulse_start
);

  // Reset to 1: a pulse already high at reset release is not seen as a new edge.
  logic pwm_q;

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b1;
    else     pwm_q <= pwm_in;
  end

  assign pulse_start = pwm_in & ~pwm_q;

endmodule

// File: rtl/skip_frame_seq.sv
module skip_frame_seq
  import skip_pkg::*;
#(
  parameter int NB = 8,
  parameter int RW = 4,
  parameter int PW = 3,
  parameter int KW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_start,
  input  skip_mode_e       mode_in,
  input  logic [NB-1:0]    mask_in,
  input  logic [RW-1:0]    ratio_in,
  output logic [PW-1:0]    pos_now,
  output skip_mode_e       mode_now,
  output logic [NB-1:0]    mask_now,
  output logic [KW-1:0]    k_now
);

  logic [PW-1:0] pos_q;
  skip_mode_e    mode_q;
  logic [NB-1:0] mask_q;
  logic [KW-1:0] k_q;
  logic          frame_start;
  logic          frame_last;
  int            frame_len;

  function automatic logic [KW-1:0] clamp_k(input logic [RW-1:0] r);
    int v;
    v = int'(r);
    if (v < 2)       v = 1;
    else if (v > NB) v = NB;
    return KW'(v);
  endfunction

  // Settings come straight from the inputs on the first pulse of a frame.
  assign frame_start = (pos_q == '0);
  assign mode_now    = frame_start ? mode_in            : mode_q;
  assign mask_now    = frame_start ? mask_in            : mask_q;
  assign k_now       = frame_start ? clamp_k(ratio_in)  : k_q;
  assign pos_now     = pos_q;

  always_comb begin
    frame_len  = (mode_now == MODE_BALANCE) ? int'(k_now) : NB;
    frame_last = (int'(pos_q) == frame_len - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      mode_q <= MODE_ROTATE;
      mask_q <= '0;
      k_q    <= KW'(1);
    end else if (pulse_start) begin
      pos_q  <= frame_last ? '0 : pos_q + PW'(1);
      mode_q <= mode_now;
      mask_q <= mask_now;
      k_q    <= k_now;
    end
  end

endmodule

// File: rtl/skip_bank_gate.sv
module skip_bank_gate
  import skip_pkg::*;
#(
  parameter int PW   = 3,
  parameter int KW   = 4,
  parameter int BANK = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwm_in,
  input  logic          pulse_start,
  input  logic [PW-1:0] pos_now,
  input  skip_mode_e    mode_now,
  input  logic          hot_now,
  input  logic [KW-1:0] k_now,
  output logic          gate
);

  logic pass_q;
  logic pass_new;
  logic pass_use;

  always_comb begin
    if (mode_now == MODE_ROTATE)
      pass_new = (int'(pos_now) != BANK);
    else
      pass_new = !(hot_now && (int'(k_now) >= 2) &&
                   (int'(pos_now) == int'(k_now) - 1));
    pass_use = pulse_start ? pass_new : pass_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q <= 1'b0;
      gate   <= 1'b0;
    end else begin
      if (pulse_start) pass_q <= pass_new;
      gate <= pwm_in & pass_use;
    end
  end

endmodule

// File: rtl/pwm_skip_mod.sv
module pwm_skip_mod
  import skip_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int RATIO_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pwm_in,
  input  logic [NUM_BANKS-1:0] hot_mask,
  input  logic                 bal_mode,
  input  logic [RATIO_W-1:0]   skip_ratio,
  output logic [NUM_BANKS-1:0] gate_out
);

  localparam int POS_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int K_W   = $clog2(NUM_BANKS + 1);

  logic                 pulse_start;
  logic [POS_W-1:0]     pos_now;
  skip_mode_e           mode_now;
  logic [NUM_BANKS-1:0] mask_now;
  logic [K_W-1:0]       k_now;
  skip_mode_e           mode_in;

  assign mode_in = skip_mode_e'(bal_mode);

  skip_edge_det i_edge (
    .clk         (clk),
    .rst         (rst),
    .pwm_in      (pwm_in),
    .pulse_start (pulse_start)
  );

  skip_frame_seq #(
    .NB (NUM_BANKS),
    .RW (RATIO_W),
    .PW (POS_W),
    .KW (K_W)
  ) i_seq (
    .clk         (clk),
    .rst         (rst),
    .pulse_start (pulse_start),
    .mode_in     (mode_in),
    .mask_in     (hot_mask),
    .ratio_in    (skip_ratio),
    .pos_now     (pos_now),
    .mode_now    (mode_now),
    .mask_now    (mask_now),
    .k_now       (k_now)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    skip_bank_gate #(
      .PW   (POS_W),
      .KW   (K_W),
      .BANK (b)
    ) i_gate (
      .clk         (clk),
      .rst         (rst),
      .pwm_in      (pwm_in),
      .pulse_start (pulse_start),
      .pos_now     (pos_now),
      .mode_now    (mode_now),
      .hot_now     (mask_now[b]),
      .k_now       (k_now),
      .gate        (gate_out[b])
    );
  end

endmodule

// File: rtl/skip_mod_checker.sv
module skip_mod_checker
  import skip_pkg::*;
#(
  parameter int NB = 8,
  parameter int PW = 3,
  parameter int KW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          pwm_in,
  input logic [NB-1:0] gate_out,
  input logic          pulse_start,
  input skip_mode_e    mode_now,
  input logic [NB-1:0] hot_now,
  input logic [KW-1:0] k_now,
  input logic [PW-1:0] pos_now
);

  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (gate_out == '0));

  assert_gate_follows_pwm_R2: assert property (@(posedge clk) disable iff (rst)
    (|gate_out) |-> $past(pwm_in));

  assert_rotate_seven_R4: assert property (@(posedge clk) disable iff (rst)
    (pulse_start && mode_now == MODE_ROTATE) |=> ($countones(gate_out) == NB - 1));

  assert_hot_skip_count_R6: assert property (@(posedge clk) disable iff (rst)
    (pulse_start && mode_now == MODE_BALANCE && int'(k_now) >= 2 &&
     int'(pos_now) == int'(k_now) - 1)
    |=> ($countones(gate_out) == NB - $countones($past(hot_now))));

  assert_ratio_range_R7: assert property (@(posedge clk) disable iff (rst)
    pulse_start |-> (int'(k_now) >= 1 && int'(k_now) <= NB));

  assert_pos_in_frame_R8: assert property (@(posedge clk) disable iff (rst)
    pulse_start |-> (int'(pos_now) < ((mode_now == MODE_BALANCE) ? int'(k_now) : NB)));

  for (genvar b = 0; b < NB; b++) begin : g_chk
    assert_no_truncate_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(gate_out[b]) |-> !$past(pwm_in));

    assert_cool_passes_R5: assert property (@(posedge clk) disable iff (rst)
      (pulse_start && mode_now == MODE_BALANCE && !hot_now[b]) |=> gate_out[b]);
  end

endmodule

bind pwm_skip_mod skip_mod_checker #(
  .NB (NUM_BANKS),
  .PW (POS_W),
  .KW (K_W)
) i_skip_chk (
  .clk         (clk),
  .rst         (rst),
  .pwm_in      (pwm_in),
  .gate_out    (gate_out),
  .pulse_start (pulse_start),
  .mode_now    (mode_now),
  .hot_now     (mask_now),
  .k_now       (k_now),
  .pos_now     (pos_now)
);

// File: tb/test_pwm_skip_mod.sv
`timescale 1ns/1ps
module test_pwm_skip_mod;

  localparam int NB = 8;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwm_in = 1'b1;
  logic [NB-1:0] hot_mask = '0;
  logic          bal_mode = 1'b0;
  logic [RW-1:0] skip_ratio = '0;
  logic [NB-1:0] gate_out;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwm_skip_mod #(.NUM_BANKS(NB), .RATIO_W(RW)) i_pwm_skip_mod (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .hot_mask(hot_mask),
    .bal_mode(bal_mode), .skip_ratio(skip_ratio), .gate_out(gate_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: frame position, sampled settings, per-bank pass.
  int            m_pos = 0;
  bit            m_prev = 1'b1;
  bit            m_pass [NB];
  logic [NB-1:0] m_exp = '0;
  bit            m_mode = 1'b0;
  logic [NB-1:0] m_mask = '0;
  int            m_k = 1;
  bit            cmp_en = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_prev = 1'b1; m_exp = '0;
      for (int b = 0; b < NB; b++) m_pass[b] = 1'b0;
    end else begin
      if (pwm_in && !m_prev) begin
        int len;
        if (m_pos == 0) begin
          m_mode = bal_mode; m_mask = hot_mask;
          m_k = int'(skip_ratio);
          if (m_k < 2) m_k = 1; else if (m_k > NB) m_k = NB;
        end
        len = m_mode ? m_k : NB;
        for (int b = 0; b < NB; b++)
          m_pass[b] = m_mode ? !(m_mask[b] && m_k >= 2 && m_pos == m_k - 1)
                             : (b != m_pos);
        m_pos = (m_pos == len - 1) ? 0 : m_pos + 1;
      end
      for (int b = 0; b < NB; b++) m_exp[b] = pwm_in && m_pass[b];
      m_prev = pwm_in;
    end
  end

  // Per-cycle comparison (R2 timing), pulse counts and pulse widths (R3).
  int            pcnt [NB];
  int            run  [NB];
  logic [NB-1:0] prev_g = '0;
  int            cur_h = 0;
  bit            width_en = 1'b0;

  initial for (int b = 0; b < NB; b++) begin pcnt[b] = 0; run[b] = 0; end

  always @(negedge clk) begin
    if (cmp_en) chk(gate_out === m_exp, "R2", "gate vs model", int'(gate_out), int'(m_exp));
    for (int b = 0; b < NB; b++) begin
      if (gate_out[b] && !prev_g[b]) pcnt[b]++;
      if (gate_out[b]) run[b]++;
      else begin
        if (prev_g[b] && width_en) chk(run[b] == cur_h, "R3", "pulse width", run[b], cur_h);
        run[b] = 0;
      end
    end
    prev_g = gate_out;
  end

  int base [NB];

  task automatic snap();
    for (int b = 0; b < NB; b++) base[b] = pcnt[b];
  endtask

  task automatic expect_counts(input string req, input logic [NB-1:0] hot,
                               input int n_hot, input int n_cool);
    for (int b = 0; b < NB; b++)
      chk(pcnt[b] - base[b] == (hot[b] ? n_hot : n_cool), req,
          $sformatf("bank %0d pulse count", b), pcnt[b] - base[b],
          hot[b] ? n_hot : n_cool);
  endtask

  task automatic pulses(input int n, input int h, input int l, input bit chk7);
    for (int i = 0; i < n; i++) begin
      cur_h = h;
      pwm_in = 1'b1;
      @(negedge clk);
      if (chk7) chk($countones(gate_out) == NB - 1, "R4", "banks conducting",
                    $countones(gate_out), NB - 1);
      repeat (h - 1) @(negedge clk);
      pwm_in = 1'b0;
      repeat (l) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state, pulse in progress at release not passed
    repeat (3) @(negedge clk);
    chk(gate_out == '0, "R1", "gates during reset", int'(gate_out), 0);
    cmp_en = 1'b1;
    rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(gate_out == '0, "R1", "pulse held over reset", int'(gate_out), 0);
    end
    pwm_in = 1'b0;
    repeat (3) @(negedge clk);
    width_en = 1'b1;

    // R4: rotation, each bank 14 of 16
    snap(); pulses(16, 3, 2, 1'b1);
    expect_counts("R4", '0, 0, 14);

    // R9: mask and ratio ignored in rotation
    hot_mask = 8'hFF; skip_ratio = 4'd4;
    snap(); pulses(8, 2, 3, 1'b1);
    expect_counts("R9", '0, 0, 7);

    // R5/R6: balancing K=2, banks 0 and 7 hot
    bal_mode = 1'b1; hot_mask = 8'h81; skip_ratio = 4'd2;
    snap(); pulses(8, 4, 2, 1'b0);
    expect_counts("R6", 8'h81, 4, 8);

    // R5: K=4 gives three quarters
    hot_mask = 8'h24; skip_ratio = 4'd4;
    snap(); pulses(8, 3, 3, 1'b0);
    expect_counts("R5", 8'h24, 6, 8);

    // R7: ratios 0 and 1 suppress nothing
    hot_mask = 8'hFF; skip_ratio = 4'd0;
    snap(); pulses(5, 2, 2, 1'b0);
    expect_counts("R7", '0, 0, 5);
    skip_ratio = 4'd1;
    snap(); pulses(5, 2, 2, 1'b0);
    expect_counts("R7", '0, 0, 5);

    // R7: ratio above bank count clamps to eight
    hot_mask = 8'h81; skip_ratio = 4'd15;
    snap(); pulses(16, 2, 2, 1'b0);
    expect_counts("R7", 8'h81, 14, 16);

    // R8: settings changed mid-frame wait for the frame end
    hot_mask = 8'hFF; skip_ratio = 4'd4;
    pulses(2, 2, 2, 1'b0);
    bal_mode = 1'b0; hot_mask = '0; skip_ratio = '0;
    snap(); pulses(2, 2, 2, 1'b0);
    expect_counts("R8", 8'hFF, 1, 1);
    snap(); pulses(8, 2, 2, 1'b1);
    expect_counts("R8", '0, 0, 7);

    // R2/R3: narrowest pulses
    snap(); pulses(8, 1, 1, 1'b1);
    expect_counts("R2", '0, 0, 7);

    // R1: reset in the middle of a pulse
    width_en = 1'b0;
    pwm_in = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    repeat (2) begin
      @(negedge clk);
      chk(gate_out == '0, "R1", "gates after mid-pulse reset", int'(gate_out), 0);
    end
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(gate_out == '0, "R1", "pulse across reset dropped", int'(gate_out), 0);
    end
    pwm_in = 1'b0;
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule